// File: doc/BRIEF.md
# Two-Bank DRAM Ready Generator

This block decides when a processor bus cycle to DRAM may finish. The DRAM is split into two banks that alternate on one address bit. For every cycle the bus master raises a one-clock start strobe together with the bank bit, a write flag and a flag that says the address was presented early, in the previous cycle. The block counts the wait states that the situation calls for and then raises ready for a single clock.

The count depends on four things. The first is whether the cycle follows the previous one with no idle clock. The second is whether it hits the bank used last, which then still needs precharge. The third is whether the address came early, and the fourth is whether the cycle writes. A built-in interval timer schedules distributed refresh. A refresh holds off any access until it has finished, and an access already running holds off a refresh until it ends. A parameter selects between a fast timing profile (two-clock reads) and a slow one (three-clock reads).

Top module: `dram_wait_ctrl`

## Requirements
- R1: Fast profile (`THREE_CLK`=0), back-to-back access to the bank not used last: 0 wait states when `addrEarly` is high, 1 when it is low.
- R2: Slow profile (`THREE_CLK`=1), back-to-back access to the bank not used last: 1 wait state with `addrEarly` high, 2 with it low.
- R3: A back-to-back access to the bank used last costs 1 wait state (fast) or 3 (slow), whatever the value of `addrEarly`.
- R4: With `isWrite` high, the access takes exactly one wait state more than the same access as a read.
- R5: A start taken while the bus is idle, including the first start after reset, counts as not early and carries no same-bank penalty.
- R6: A start counts as back-to-back only if it is sampled on the clock edge that ends the single ready clock. With W wait states, `ready` rises W+1 edges after the edge that accepts the start and stays high for exactly one clock.
- R7: Call the first rising edge with `rst_n` high edge 1. A refresh request fires on every edge whose number is a multiple of `REFRESH_INTERVAL`. If the bus is idle, `refreshBusy` rises on that edge and stays high for `REFRESH_LEN` clocks.
- R8: A refresh request that fires during an access waits until that access's ready clock has passed. A start given in that ready clock then runs after the refresh as an idle-bus access. Its wait count is `REFRESH_LEN` plus the idle-bus count.
- R9: A start that meets a refresh is delayed until the refresh ends and is then timed as an idle-bus access. This covers a start given while `refreshBusy` is high and a start on the same edge as the refresh request. The wait count is the idle-bus count plus the refresh clocks left at acceptance: `REFRESH_LEN` when the start coincides with the request, and one less for each refresh clock already elapsed.
- R10: With the default `REFRESH_LEN`, no access ever sees more than 4 wait states (fast) or 8 (slow).
- R11: During reset and right after it, `ready` and `refreshBusy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycStart | input | 1 | One-clock strobe opening a bus cycle |
| bankSel | input | 1 | Bank chosen by the interleave address bit |
| isWrite | input | 1 | High for a write cycle |
| addrEarly | input | 1 | Address was presented one clock ahead |
| ready | output | 1 | One-clock pulse ending the bus cycle |
| refreshBusy | output | 1 | High while a refresh occupies the DRAM |

## Verification
Every cycle, the assertions check that ready is a lone pulse answering an accepted start. They also check that each refresh lasts exactly its programmed length and that no access exceeds the refresh-stretched ceiling. The exact wait counts in the profile and bank tables, the idle and back-to-back distinction, and the write penalty can only be shown by the bench's scenarios. The same holds for the ordering between an access and a refresh. Those scenarios time starts against known refresh edges and compare the measured latency with counts derived from the requirements.

// File: rtl/dram_ws_pkg.sv
package dram_ws_pkg;

  // wide enough for the largest table entry plus the write penalty
  localparam int WAIT_W = 4;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_READY,
    S_REFRESH
  } ctrlState_t;

  // strobes issued by the sequencer to the counting datapath
  typedef struct packed {
    logic startNow;     // begin an access from the bus inputs
    logic b2b;          // qualifies startNow: cycle follows ready directly
    logic capturePend;  // park the bus inputs behind a refresh
    logic startPend;    // begin the parked access after refresh
    logic loadRef;      // open a refresh window
    logic decWait;      // count one wait clock
    logic decRef;       // count one refresh clock
  } ctrlStrobe_t;

  // Wait states for one access under the selected timing profile.
  function automatic logic [WAIT_W-1:0] waitStates(
    input logic threeClk,
    input logic b2b,
    input logic early,
    input logic same,
    input logic write
  );
    logic [WAIT_W-1:0] base;
    if (b2b && same)
      base = threeClk ? WAIT_W'(3) : WAIT_W'(1);
    else if (b2b && early)
      base = threeClk ? WAIT_W'(1) : WAIT_W'(0);
    else
      base = threeClk ? WAIT_W'(2) : WAIT_W'(1);
    return base + WAIT_W'(write);
  endfunction

endpackage

// File: rtl/dram_ws_datapath.sv
module dram_ws_datapath
  import dram_ws_pkg::*;
#(
  parameter bit THREE_CLK   = 1'b0,
  parameter int REFRESH_LEN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t st,
  input  logic        bankSel,
  input  logic        isWrite,
  input  logic        addrEarly,
  output logic        waitZero,
  output logic        refDone
);

  localparam int REF_W = (REFRESH_LEN > 1) ? $clog2(REFRESH_LEN + 1) : 1;

  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic              lastBank;
  logic              pendBank;
  logic              pendWrite;

  logic sameBank;
  logic effBank;
  logic effWrite;
  logic [WAIT_W-1:0] liveWait;
  logic [WAIT_W-1:0] parkedWait;

  assign sameBank = (bankSel == lastBank);
  // a start sampled on the very edge the refresh ends bypasses the park regs
  assign effBank  = st.capturePend ? bankSel : pendBank;
  assign effWrite = st.capturePend ? isWrite : pendWrite;

  assign liveWait   = waitStates(THREE_CLK, st.b2b, addrEarly, sameBank, isWrite);
  // after a refresh the bus counts as idle: no early credit, precharge done
  assign parkedWait = waitStates(THREE_CLK, 1'b0, 1'b0, 1'b0, effWrite);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitCnt  <= '0;
      lastBank <= 1'b0;
    end else if (st.startNow) begin
      waitCnt  <= liveWait;
      lastBank <= bankSel;
    end else if (st.startPend) begin
      waitCnt  <= parkedWait;
      lastBank <= effBank;
    end else if (st.decWait && waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendBank  <= 1'b0;
      pendWrite <= 1'b0;
    end else if (st.capturePend) begin
      pendBank  <= bankSel;
      pendWrite <= isWrite;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      refCnt <= '0;
    else if (st.loadRef)
      refCnt <= REF_W'(REFRESH_LEN - 1);
    else if (st.decRef && refCnt != '0)
      refCnt <= refCnt - 1'b1;
  end

  assign waitZero = (waitCnt == '0);
  assign refDone  = (refCnt == '0);

endmodule

// File: rtl/dram_ws_ctrl.sv
module dram_ws_ctrl
  import dram_ws_pkg::*;
#(
  parameter int REFRESH_INTERVAL = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cycStart,
  input  logic        waitZero,
  input  logic        refDone,
  output ctrlStrobe_t st,
  output logic        ready,
  output logic        refreshBusy
);

  localparam int TMR_W = (REFRESH_INTERVAL > 1) ? $clog2(REFRESH_INTERVAL) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REFRESH_INTERVAL - 1);

  ctrlState_t       state, nextState;
  logic [TMR_W-1:0] timer;
  logic             tick;
  logic             refPending;
  logic             refWant;
  logic             pendValid;
  logic             pendSet;
  logic             pendClr;

  // interval timer: one request every REFRESH_INTERVAL clocks
  assign tick = (timer == TMR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      timer <= '0;
    else if (tick)
      timer <= '0;
    else
      timer <= timer + 1'b1;
  end

  assign refWant = refPending | tick;

  always_comb begin
    st        = '0;
    nextState = state;
    pendSet   = 1'b0;
    pendClr   = 1'b0;
    unique case (state)
      S_IDLE, S_READY: begin
        if (refWant) begin
          nextState  = S_REFRESH;
          st.loadRef = 1'b1;
          if (cycStart) begin
            st.capturePend = 1'b1;
            pendSet        = 1'b1;
          end
        end else if (cycStart) begin
          nextState   = S_WAIT;
          st.startNow = 1'b1;
          st.b2b      = (state == S_READY);
        end else begin
          nextState = S_IDLE;
        end
      end
      S_WAIT: begin
        st.decWait = 1'b1;
        if (waitZero) nextState = S_READY;
      end
      S_REFRESH: begin
        st.decRef = 1'b1;
        if (cycStart && !pendValid) begin
          st.capturePend = 1'b1;
          pendSet        = 1'b1;
        end
        if (refDone) begin
          if (pendValid || cycStart) begin
            st.startPend = 1'b1;
            nextState    = S_WAIT;
            pendClr      = 1'b1;
          end else begin
            nextState = S_IDLE;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      refPending <= 1'b0;
      pendValid  <= 1'b0;
    end else begin
      state <= nextState;
      if (st.loadRef)
        refPending <= 1'b0;
      else if (tick)
        refPending <= 1'b1;
      if (pendClr)
        pendValid <= 1'b0;
      else if (pendSet)
        pendValid <= 1'b1;
    end
  end

  assign ready       = (state == S_READY);
  assign refreshBusy = (state == S_REFRESH);

endmodule

// File: rtl/dram_wait_ctrl.sv
module dram_wait_ctrl
  import dram_ws_pkg::*;
#(
  parameter bit THREE_CLK        = 1'b0,
  parameter int REFRESH_INTERVAL = 512,
  parameter int REFRESH_LEN      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycStart,
  input  logic bankSel,
  input  logic isWrite,
  input  logic addrEarly,
  output logic ready,
  output logic refreshBusy
);

  ctrlStrobe_t strobe;
  logic        waitZero;
  logic        refDone;

  dram_ws_ctrl #(
    .REFRESH_INTERVAL(REFRESH_INTERVAL)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycStart   (cycStart),
    .waitZero   (waitZero),
    .refDone    (refDone),
    .st         (strobe),
    .ready      (ready),
    .refreshBusy(refreshBusy)
  );

  dram_ws_datapath #(
    .THREE_CLK  (THREE_CLK),
    .REFRESH_LEN(REFRESH_LEN)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (strobe),
    .bankSel  (bankSel),
    .isWrite  (isWrite),
    .addrEarly(addrEarly),
    .waitZero (waitZero),
    .refDone  (refDone)
  );

endmodule

// File: rtl/dram_wait_ctrl_chk.sv
module dram_wait_ctrl_chk #(
  parameter bit THREE_CLK   = 1'b0,
  parameter int REFRESH_LEN = 2
) (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic ready,
  input logic refreshBusy
);

  localparam int CAP = THREE_CLK ? 8 : 4;

  logic        run;
  logic [4:0]  elapsed;
  logic [15:0] busyLen;

  // clocks since the start was accepted; ready sampled at elapsed = W+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      elapsed <= '0;
    end else if (accept) begin
      run     <= 1'b1;
      elapsed <= '0;
    end else if (ready) begin
      run <= 1'b0;
    end else if (run && elapsed != '1) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busyLen <= '0;
    else if (refreshBusy)
      busyLen <= busyLen + 1'b1;
    else
      busyLen <= '0;
  end

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);  // R6

  AST_READY_ANSWERS_START: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> run);  // R6

  AST_REFRESH_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refreshBusy) |-> (busyLen == 16'(REFRESH_LEN)));  // R7

  AST_STRETCH_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && run) |-> (int'(elapsed) <= CAP + 1));  // R10

  AST_NO_INSTANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);  // R6

endmodule

bind dram_wait_ctrl dram_wait_ctrl_chk #(
  .THREE_CLK  (THREE_CLK),
  .REFRESH_LEN(REFRESH_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (strobe.startNow | strobe.capturePend),
  .ready      (ready),
  .refreshBusy(refreshBusy)
);

// File: tb/dram_wait_ctrl_tb.sv
module dram_wait_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 64;
  localparam int RLEN       = 2;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic cycStart [2];
  logic bankSel  [2];
  logic isWrite  [2];
  logic addrEarly[2];
  logic ready    [2];
  logic refreshBusy[2];

  int cyc    = 0;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int    expQ0[$];
  int    expQ1[$];
  string tagQ0[$];
  string tagQ1[$];
  bit    active [2];
  int    elapsed[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  // fast profile
  dram_wait_ctrl #(.THREE_CLK(1'b0), .REFRESH_INTERVAL(INTERVAL), .REFRESH_LEN(RLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cycStart(cycStart[0]), .bankSel(bankSel[0]),
    .isWrite(isWrite[0]), .addrEarly(addrEarly[0]), .ready(ready[0]),
    .refreshBusy(refreshBusy[0]));

  // slow profile
  dram_wait_ctrl #(.THREE_CLK(1'b1), .REFRESH_INTERVAL(INTERVAL), .REFRESH_LEN(RLEN)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .cycStart(cycStart[1]), .bankSel(bankSel[1]),
    .isWrite(isWrite[1]), .addrEarly(addrEarly[1]), .ready(ready[1]),
    .refreshBusy(refreshBusy[1]));

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // wait states derived from the requirement tables
  function automatic int ew(input int p, input bit b2b, input bit same,
                            input bit early, input bit wr);
    int base;
    if (b2b && same)       base = (p == 1) ? 3 : 1;
    else if (b2b && early) base = (p == 1) ? 1 : 0;
    else                   base = (p == 1) ? 2 : 1;
    return base + int'(wr);
  endfunction

  task automatic popCheck(input int p, input int meas);
    int    e;
    string t;
    if ((p == 0 ? expQ0.size() : expQ1.size()) == 0) begin
      check(1'b0, "R6 ready with no open cycle", meas, -1);
    end else begin
      if (p == 0) begin e = expQ0.pop_front(); t = tagQ0.pop_front(); end
      else        begin e = expQ1.pop_front(); t = tagQ1.pop_front(); end
      check(meas == e, $sformatf("%s profile%0d wait states", t, p), meas, e);
    end
  endtask

  // monitor: time each accepted start to its ready pulse
  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (!rst_n) begin
        active[p] = 1'b0;
      end else if (cycStart[p]) begin
        active[p]  = 1'b1;
        elapsed[p] = 0;
      end else if (active[p]) begin
        elapsed[p]++;
      end
    end
  end

  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (active[p] && ready[p]) begin
        popCheck(p, elapsed[p] - 1);
        active[p] = 1'b0;
      end
    end
  end

  task automatic waitCyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  // driver: open a cycle at this falling edge, queue its expected count,
  // return at the falling edge where ready is seen high
  task automatic access(input int p, input logic bank, input logic wr,
                        input logic early, input int expW, input string tag);
    cycStart[p]  = 1'b1;
    bankSel[p]   = bank;
    isWrite[p]   = wr;
    addrEarly[p] = early;
    if (p == 0) begin expQ0.push_back(expW); tagQ0.push_back(tag); end
    else        begin expQ1.push_back(expW); tagQ1.push_back(tag); end
    @(negedge clk);
    cycStart[p] = 1'b0;
    while (!ready[p]) @(negedge clk);
  endtask

  task automatic runSeq(input int p);
    waitCyc(2);
    access(p, 1'b0, 1'b0, 1'b1, ew(p, 0, 0, 1, 0), "R5 first after reset");
    access(p, 1'b1, 1'b0, 1'b1, ew(p, 1, 0, 1, 0), "R1 R2 R6 alt bank early");
    access(p, 1'b1, 1'b0, 1'b1, ew(p, 1, 1, 1, 0), "R3 same bank early");
    access(p, 1'b0, 1'b0, 1'b0, ew(p, 1, 0, 0, 0), "R1 R2 alt bank late");
    access(p, 1'b1, 1'b1, 1'b1, ew(p, 1, 0, 1, 1), "R4 alt bank write");
    access(p, 1'b1, 1'b1, 1'b1, ew(p, 1, 1, 1, 1), "R3 R4 same bank write");
    repeat (3) @(negedge clk);
    access(p, 1'b1, 1'b0, 1'b1, ew(p, 0, 1, 1, 0), "R5 after idle same bank");
    access(p, 1'b0, 1'b1, 1'b0, ew(p, 1, 0, 0, 1), "R4 alt bank late write");
    // start while the refresh from edge 64 is running (one clock elapsed)
    waitCyc(64);
    access(p, 1'b0, 1'b0, 1'b1, RLEN + ew(p, 0, 0, 0, 0) - 1, "R9 start during refresh");
    // access spans the request at edge 128; next start waits for the refresh
    waitCyc(125);
    access(p, 1'b0, 1'b0, 1'b0, ew(p, 0, 0, 0, 0), "R5 idle read");
    access(p, 1'b0, 1'b1, 1'b1, RLEN + ew(p, 0, 0, 0, 1), "R8 R10 start behind held refresh");
    // start on the same edge as the request at edge 192
    waitCyc(191);
    access(p, 1'b1, 1'b0, 1'b1, RLEN + ew(p, 0, 0, 0, 0), "R9 start meets refresh edge");
    repeat (4) @(negedge clk);
  endtask

  task automatic busyObs(input int p);
    waitCyc(63);
    check(refreshBusy[p] == 1'b0, "R7 busy before request", int'(refreshBusy[p]), 0);
    waitCyc(64);
    check(refreshBusy[p] == 1'b1, "R7 busy on request edge", int'(refreshBusy[p]), 1);
    waitCyc(65);
    check(refreshBusy[p] == 1'b1, "R7 busy second clock", int'(refreshBusy[p]), 1);
    waitCyc(66);
    check(refreshBusy[p] == 1'b0, "R7 busy after length", int'(refreshBusy[p]), 0);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      cycStart[p]  = 1'b0;
      bankSel[p]   = 1'b0;
      isWrite[p]   = 1'b0;
      addrEarly[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      check(ready[p] == 1'b0, "R11 ready in reset", int'(ready[p]), 0);
      check(refreshBusy[p] == 1'b0, "R11 busy in reset", int'(refreshBusy[p]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 2; p++)
      check(ready[p] == 1'b0, "R11 ready after reset", int'(ready[p]), 0);
    fork
      runSeq(0);
      runSeq(1);
      busyObs(0);
      busyObs(1);
    join
    check(expQ0.size() == 0, "R6 fast profile cycles left open", expQ0.size(), 0);
    check(expQ1.size() == 0, "R6 slow profile cycles left open", expQ1.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule